// File: doc/BRIEF.md
# Opcode Map Escape Decoder

This block sits behind a prefix scanner in an instruction decode pipeline. The scanner hands it a summary of the prefixes it found: the repeat class of the instruction and whether an operand-size override was seen. The decoder then accepts the opcode bytes one per cycle on a valid/ready stream. It follows the escape byte 0Fh and the second-level selectors 38h and 3Ah to find the opcode map in use. It stops after one, two or three bytes and reports the map, the length, the final opcode byte and the mandatory prefix in effect.

For an escaped map, a repeat or operand-size prefix in the summary acts as a map selector and no longer acts as a modifier. The decoder picks that selector and clears its modifier meaning in the flags it passes on. A companion table that says whether a ModR/M byte follows is consulted through a small combinational lookup port. The decoder presents the candidate map and byte on that port every cycle. It latches the answer when the final byte is taken.

One instruction is handled at a time. The result is held on the output until the consumer takes it, and no new byte is accepted while a result is pending.

Top module: `opmap_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A first byte other than 0Fh ends the instruction at once with map 0, length 1 and opcode equal to that byte. The mandatory-prefix code is 0 (none), and the repeat class and operand-size flag are passed through.
- R3: 0Fh followed by a byte other than 38h and 3Ah ends the instruction with map 1, length 2, and the second byte as opcode. A second 0Fh is an ordinary opcode here.
- R4: 0Fh 38h followed by any byte gives map 2, and 0Fh 3Ah followed by any byte gives map 3. Both have length 3 and the third byte as opcode.
- R5: For maps 1 to 3 the mandatory-prefix code is chosen as follows. It is 3 when the repeat class is 2 (F2h) and 2 when the repeat class is 1 (F3h). Only when there is no repeat class is it 1 (66h), if the operand-size flag is set, and otherwise 0. Repeat class code 3 means no repeat prefix and is reported as 0.
- R6: The prefix chosen as mandatory loses its modifier meaning. Code 2 or 3 forces `out_rep` to 0 while keeping `out_opsize`. Code 1 forces `out_opsize` to 0.
- R7: When `in_valid` is low in the middle of a sequence, the decoder waits with no output and no state change. The result is the same as for a sequence with no gaps.
- R8: The prefix summary is sampled only with the first byte. Changes to it while later bytes of the same instruction arrive have no effect.
- R9: While `out_valid` is high and `out_ready` is low, all result outputs hold steady. `in_ready` is low whenever `out_valid` is high.
- R10: `out_valid` rises in the cycle right after the clock edge that accepts the final byte.
- R11: `lk_map` and `lk_opcode` show the map of the byte being offered and the byte itself. The value of `lk_modrm` at the edge that takes the final byte is reported on `out_modrm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An opcode byte is offered |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| in_byte | input | BYTE_W | Opcode byte |
| pfx_rep | input | 2 | Repeat class: 0 none, 1 F3h, 2 F2h, 3 none |
| pfx_opsize | input | 1 | Operand-size override present |
| lk_map | output | 2 | Map of the byte offered, for the ModR/M table |
| lk_opcode | output | BYTE_W | Byte offered, for the ModR/M table |
| lk_modrm | input | 1 | Table answer: a ModR/M byte follows |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_opcode | output | BYTE_W | Final opcode byte |
| out_map | output | 2 | Map: 0 one-byte, 1 0Fh, 2 0Fh 38h, 3 0Fh 3Ah |
| out_len | output | 2 | Opcode length in bytes (1 to 3) |
| out_mand | output | 2 | Mandatory prefix: 0 none, 1 66h, 2 F3h, 3 F2h |
| out_rep | output | 2 | Repeat class left as a modifier |
| out_opsize | output | 1 | Operand-size override left as a modifier |
| out_modrm | output | 1 | Latched ModR/M answer |

## Verification
The bench targets several corner cases, each tied to a specific fault. The first is a 0Fh in second position: a decoder that treats it as another escape would hang or report length 3. The second is 38h as a first byte: a decoder that reacts to selectors outside the second position would leave map 0. A summary carrying both F2h and 66h, and another carrying both F3h and 66h, expose a wrong precedence or a modifier flag that is left set or cleared wrongly. Idle gaps inside a sequence, a summary that changes after the first byte, and a consumer that holds off the result catch a decoder that loses state, samples the prefix late, or lets a pending result drift.

// File: rtl/opmap_pkg.sv
package opmap_pkg;

  typedef enum logic [1:0] {
    MAP_ONE   = 2'd0,
    MAP_ESC   = 2'd1,
    MAP_ESC_A = 2'd2,
    MAP_ESC_B = 2'd3
  } map_e;

  typedef enum logic [1:0] {
    MP_NONE  = 2'd0,
    MP_OPSZ  = 2'd1,
    MP_REP   = 2'd2,
    MP_REPNE = 2'd3
  } mand_e;

  typedef enum logic [1:0] {
    W_FIRST  = 2'd0,
    W_SECOND = 2'd1,
    W_THIRD  = 2'd2,
    W_DONE   = 2'd3
  } walk_e;

  localparam logic [1:0] REP_NONE = 2'd0;
  localparam logic [1:0] REP_F3   = 2'd1;
  localparam logic [1:0] REP_F2   = 2'd2;

  // Map chosen by the byte after the escape.
  function automatic map_e f_sel_map(input logic [7:0] b,
                                     input logic [7:0] sel_a,
                                     input logic [7:0] sel_b);
    if (b == sel_a)      return MAP_ESC_A;
    else if (b == sel_b) return MAP_ESC_B;
    else                 return MAP_ESC;
  endfunction

  // Repeat class code 3 carries no prefix.
  function automatic logic [1:0] f_norm_rep(input logic [1:0] r);
    return (r == 2'd3) ? REP_NONE : r;
  endfunction

  // Repeat prefixes take precedence over the operand-size override.
  function automatic mand_e f_mand(input logic escaped,
                                   input logic [1:0] rep_n,
                                   input logic opsz);
    if (!escaped)              return MP_NONE;
    else if (rep_n == REP_F2)  return MP_REPNE;
    else if (rep_n == REP_F3)  return MP_REP;
    else if (opsz)             return MP_OPSZ;
    else                       return MP_NONE;
  endfunction

endpackage

// File: rtl/opmap_walk.sv
module opmap_walk
  import opmap_pkg::*;
#(
  parameter int unsigned   BYTE_W   = 8,
  parameter logic [7:0]    ESC_CODE = 8'h0F,
  parameter logic [7:0]    SEL_A    = 8'h38,
  parameter logic [7:0]    SEL_B    = 8'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              first_take,
  output logic              fin_take,
  output map_e              cur_map,
  output logic [1:0]        cur_len
);

  walk_e state_q, state_d;
  map_e  map_q,   map_d;
  map_e  sel;
  logic  take;
  logic  is_esc;
  logic  is_fin;

  assign in_ready   = (state_q != W_DONE);
  assign out_valid  = (state_q == W_DONE);
  assign take       = in_valid && in_ready;
  assign is_esc     = (in_byte[7:0] == ESC_CODE);
  assign sel        = f_sel_map(in_byte[7:0], SEL_A, SEL_B);
  assign first_take = take && (state_q == W_FIRST);
  assign fin_take   = take && is_fin;

  always_comb begin
    is_fin  = 1'b0;
    cur_map = MAP_ONE;
    cur_len = 2'd1;
    unique case (state_q)
      W_FIRST: begin
        is_fin  = !is_esc;
        cur_map = MAP_ONE;
        cur_len = 2'd1;
      end
      W_SECOND: begin
        is_fin  = (sel == MAP_ESC);
        cur_map = MAP_ESC;
        cur_len = 2'd2;
      end
      W_THIRD: begin
        is_fin  = 1'b1;
        cur_map = map_q;
        cur_len = 2'd3;
      end
      default: begin
        is_fin  = 1'b0;
        cur_map = map_q;
        cur_len = 2'd3;
      end
    endcase
  end

  always_comb begin
    state_d = state_q;
    map_d   = map_q;
    unique case (state_q)
      W_FIRST:  if (take) state_d = is_esc ? W_SECOND : W_DONE;
      W_SECOND: if (take) begin
        if (sel == MAP_ESC) state_d = W_DONE;
        else begin
          state_d = W_THIRD;
          map_d   = sel;
        end
      end
      W_THIRD:  if (take) state_d = W_DONE;
      default:  if (out_ready) state_d = W_FIRST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_FIRST;
      map_q   <= MAP_ONE;
    end else begin
      state_q <= state_d;
      map_q   <= map_d;
    end
  end

endmodule

// File: rtl/opmap_prefix.sv
module opmap_prefix
  import opmap_pkg::*;
(
  input  logic       escaped,
  input  logic [1:0] rep_in,
  input  logic       opsz_in,
  output mand_e      mand,
  output logic [1:0] rep_out,
  output logic       opsz_out
);

  logic [1:0] rep_n;

  assign rep_n    = f_norm_rep(rep_in);
  assign mand     = f_mand(escaped, rep_n, opsz_in);
  assign rep_out  = (mand == MP_REP || mand == MP_REPNE) ? REP_NONE : rep_n;
  assign opsz_out = (mand == MP_OPSZ) ? 1'b0 : opsz_in;

endmodule

// File: rtl/opmap_hold.sv
module opmap_hold
  import opmap_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_take,
  input  logic              fin_take,
  input  logic [1:0]        pfx_rep,
  input  logic              pfx_opsize,
  input  logic [BYTE_W-1:0] in_byte,
  input  map_e              cur_map,
  input  logic [1:0]        cur_len,
  input  mand_e             mand,
  input  logic [1:0]        rep_res,
  input  logic              opsz_res,
  input  logic              lk_modrm,
  output logic [1:0]        src_rep,
  output logic              src_opsz,
  output logic [BYTE_W-1:0] r_opcode,
  output logic [1:0]        r_map,
  output logic [1:0]        r_len,
  output logic [1:0]        r_mand,
  output logic [1:0]        r_rep,
  output logic              r_opsz,
  output logic              r_modrm
);

  logic [1:0] cap_rep;
  logic       cap_opsz;

  // A one-byte instruction finishes in the same cycle its prefix arrives.
  assign src_rep  = first_take ? pfx_rep    : cap_rep;
  assign src_opsz = first_take ? pfx_opsize : cap_opsz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_rep  <= 2'd0;
      cap_opsz <= 1'b0;
    end else if (first_take) begin
      cap_rep  <= pfx_rep;
      cap_opsz <= pfx_opsize;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_opcode <= '0;
      r_map    <= 2'd0;
      r_len    <= 2'd0;
      r_mand   <= 2'd0;
      r_rep    <= 2'd0;
      r_opsz   <= 1'b0;
      r_modrm  <= 1'b0;
    end else if (fin_take) begin
      r_opcode <= in_byte;
      r_map    <= cur_map;
      r_len    <= cur_len;
      r_mand   <= mand;
      r_rep    <= rep_res;
      r_opsz   <= opsz_res;
      r_modrm  <= lk_modrm;
    end
  end

endmodule

// File: rtl/opmap_decoder.sv
module opmap_decoder
  import opmap_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter logic [7:0]  ESC_CODE = 8'h0F,
  parameter logic [7:0]  SEL_A    = 8'h38,
  parameter logic [7:0]  SEL_B    = 8'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [1:0]        pfx_rep,
  input  logic              pfx_opsize,
  output logic [1:0]        lk_map,
  output logic [BYTE_W-1:0] lk_opcode,
  input  logic              lk_modrm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_opcode,
  output logic [1:0]        out_map,
  output logic [1:0]        out_len,
  output logic [1:0]        out_mand,
  output logic [1:0]        out_rep,
  output logic              out_opsize,
  output logic              out_modrm
);

  // Named internal events for the checker.
  logic       first_take;
  logic       fin_take;
  map_e       cur_map;
  logic [1:0] cur_len;
  logic [1:0] src_rep;
  logic       src_opsz;
  mand_e      mand;
  logic [1:0] rep_res;
  logic       opsz_res;
  logic       escaped;

  assign escaped   = (cur_map != MAP_ONE);
  assign lk_map    = cur_map;
  assign lk_opcode = in_byte;

  opmap_walk #(
    .BYTE_W(BYTE_W), .ESC_CODE(ESC_CODE), .SEL_A(SEL_A), .SEL_B(SEL_B)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .first_take(first_take), .fin_take(fin_take),
    .cur_map(cur_map), .cur_len(cur_len)
  );

  opmap_prefix u_prefix (
    .escaped(escaped), .rep_in(src_rep), .opsz_in(src_opsz),
    .mand(mand), .rep_out(rep_res), .opsz_out(opsz_res)
  );

  opmap_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .first_take(first_take), .fin_take(fin_take),
    .pfx_rep(pfx_rep), .pfx_opsize(pfx_opsize), .in_byte(in_byte),
    .cur_map(cur_map), .cur_len(cur_len), .mand(mand),
    .rep_res(rep_res), .opsz_res(opsz_res), .lk_modrm(lk_modrm),
    .src_rep(src_rep), .src_opsz(src_opsz),
    .r_opcode(out_opcode), .r_map(out_map), .r_len(out_len),
    .r_mand(out_mand), .r_rep(out_rep), .r_opsz(out_opsize),
    .r_modrm(out_modrm)
  );

endmodule

// File: rtl/opmap_decoder_chk.sv
module opmap_decoder_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_opcode,
  input logic [1:0]        out_map,
  input logic [1:0]        out_len,
  input logic [1:0]        out_mand,
  input logic [1:0]        out_rep,
  input logic              out_opsize,
  input logic              fin_take
);

  // R9
  hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) &&
      $stable(out_map) && $stable(out_len) && $stable(out_mand) &&
      $stable(out_rep) && $stable(out_opsize)));

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R10
  fin_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_take |=> out_valid);

  // R10
  out_from_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(fin_take));

  // R2
  one_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_map == 2'd0) |-> (out_len == 2'd1 && out_mand == 2'd0));

  // R3
  esc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_map == 2'd1) |-> (out_len == 2'd2));

  // R4
  three_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_map[1]) |-> (out_len == 2'd3));

  // R6
  opsz_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mand == 2'd1) |-> !out_opsize);

  // R6
  rep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mand[1]) |-> (out_rep == 2'd0));

endmodule

bind opmap_decoder opmap_decoder_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/opmap_decoder_bench.sv
module opmap_decoder_bench;

  typedef struct {
    logic [7:0] opcode;
    logic [1:0] map;
    logic [1:0] len;
    logic [1:0] mand;
    logic [1:0] rep;
    logic       opsz;
    logic       modrm;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic [1:0] pfx_rep = 2'd0;
  logic       pfx_opsize = 1'b0;
  logic [1:0] lk_map;
  logic [7:0] lk_opcode;
  logic       lk_modrm;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_opcode;
  logic [1:0] out_map;
  logic [1:0] out_len;
  logic [1:0] out_mand;
  logic [1:0] out_rep;
  logic       out_opsize;
  logic       out_modrm;

  int   n_chk = 0;
  int   n_bad = 0;
  exp_t sb[$];
  logic [3:0] lfsr = 4'b1011;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  // Stand-in ModR/M table (R11): a fixed function of map and byte.
  function automatic logic tbl(input logic [1:0] m, input logic [7:0] b);
    return b[0] ^ b[7] ^ m[0];
  endfunction
  assign lk_modrm = tbl(lk_map, lk_opcode);

  opmap_decoder u_opmap_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .pfx_rep(pfx_rep), .pfx_opsize(pfx_opsize),
    .lk_map(lk_map), .lk_opcode(lk_opcode), .lk_modrm(lk_modrm),
    .out_valid(out_valid), .out_ready(out_ready), .out_opcode(out_opcode),
    .out_map(out_map), .out_len(out_len), .out_mand(out_mand),
    .out_rep(out_rep), .out_opsize(out_opsize), .out_modrm(out_modrm)
  );

  task automatic check(input string req, input logic ok,
                       input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] rep, input logic ops,
                                 input logic [7:0] b0, input logic [7:0] b1,
                                 input logic [7:0] b2, input string tag);
    exp_t e;
    logic [1:0] rn;
    rn = (rep == 2'd3) ? 2'd0 : rep;
    if (b0 != 8'h0F)      begin e.map = 2'd0; e.len = 2'd1; e.opcode = b0; end
    else if (b1 == 8'h38) begin e.map = 2'd2; e.len = 2'd3; e.opcode = b2; end
    else if (b1 == 8'h3A) begin e.map = 2'd3; e.len = 2'd3; e.opcode = b2; end
    else                  begin e.map = 2'd1; e.len = 2'd2; e.opcode = b1; end
    if (e.map == 2'd0)    e.mand = 2'd0;
    else if (rn == 2'd2)  e.mand = 2'd3;
    else if (rn == 2'd1)  e.mand = 2'd2;
    else if (ops)         e.mand = 2'd1;
    else                  e.mand = 2'd0;
    e.rep   = (e.mand >= 2'd2) ? 2'd0 : rn;
    e.opsz  = (e.mand == 2'd1) ? 1'b0 : ops;
    e.modrm = tbl(e.map, e.opcode);
    e.tag   = tag;
    return e;
  endfunction

  // Driver: pushes the expected item, then feeds the bytes.
  task automatic send(input string tag, input logic [1:0] rep, input logic ops,
                      input int n, input logic [7:0] b0, input logic [7:0] b1,
                      input logic [7:0] b2, input int gap, input logic swap);
    logic [7:0] bytes [3];
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    sb.push_back(model(rep, ops, b0, b1, b2, tag));
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          in_valid = 1'b0;
          in_byte  = 8'h0F;
          @(negedge clk);
          // R7: no result while the sequence is incomplete
          check("R7", out_valid == 1'b0, $sformatf("%0d", out_valid), "0");
        end
      end
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_byte  = bytes[i];
      if (i == 0) begin
        pfx_rep = rep; pfx_opsize = ops;
      end else if (swap) begin
        pfx_rep = ~rep; pfx_opsize = ~ops;  // R8: later changes ignored
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      if (i == n - 1)
        // R10: result visible right after the final byte's edge
        check("R10", out_valid == 1'b1, $sformatf("%0d", out_valid), "1");
    end
  endtask

  // Consumer throttle, changed away from the sampling edge.
  always @(posedge clk) begin
    #2;
    lfsr      <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
    out_ready <= lfsr[0] | lfsr[1];
  end

  // Monitor: pops and compares each result as it is taken.
  logic       held = 1'b0;
  logic [7:0] h_op;
  logic [1:0] h_map, h_len, h_mand;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        // R9: pending result held steady while not taken
        check("R9", out_valid && out_opcode == h_op && out_map == h_map &&
              out_len == h_len && out_mand == h_mand,
              $sformatf("v=%0d op=%h", out_valid, out_opcode),
              $sformatf("v=1 op=%h", h_op));
      end
      held = out_valid && !out_ready;
      h_op = out_opcode; h_map = out_map; h_len = out_len; h_mand = out_mand;
      if (out_valid) begin
        // R9: no byte accepted while a result is pending
        check("R9", in_ready == 1'b0, $sformatf("%0d", in_ready), "0");
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check("R10", 1'b0, "unexpected result", "none");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag,
                out_opcode == e.opcode && out_map == e.map && out_len == e.len &&
                out_mand == e.mand && out_rep == e.rep && out_opsize == e.opsz &&
                out_modrm == e.modrm,
                $sformatf("op=%h map=%0d len=%0d mand=%0d rep=%0d os=%0d mr=%0d",
                          out_opcode, out_map, out_len, out_mand, out_rep,
                          out_opsize, out_modrm),
                $sformatf("op=%h map=%0d len=%0d mand=%0d rep=%0d os=%0d mr=%0d",
                          e.opcode, e.map, e.len, e.mand, e.rep, e.opsz, e.modrm));
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1", out_valid == 1'b0 && in_ready == 1'b1,
          $sformatf("ov=%0d ir=%0d", out_valid, in_ready), "ov=0 ir=1");

    send("R2 plain",        2'd0, 1'b0, 1, 8'h90, 8'h00, 8'h00, 0, 1'b0);
    send("R2 passthru",     2'd1, 1'b1, 1, 8'hA5, 8'h00, 8'h00, 0, 1'b0);
    send("R2 sel first",    2'd2, 1'b1, 1, 8'h38, 8'h00, 8'h00, 0, 1'b0);
    send("R3 R11 esc",      2'd0, 1'b0, 2, 8'h0F, 8'h05, 8'h00, 0, 1'b0);
    send("R3 double esc",   2'd0, 1'b1, 2, 8'h0F, 8'h0F, 8'h00, 0, 1'b0);
    send("R5 R6 F3 mand",   2'd1, 1'b0, 2, 8'h0F, 8'hE6, 8'h00, 0, 1'b0);
    send("R4 R5 66 map2",   2'd0, 1'b1, 3, 8'h0F, 8'h38, 8'h01, 0, 1'b0);
    send("R4 R6 F2 map3",   2'd2, 1'b1, 3, 8'h0F, 8'h3A, 8'h0F, 0, 1'b0);
    send("R5 F3 over 66",   2'd1, 1'b1, 2, 8'h0F, 8'h10, 8'h00, 0, 1'b0);
    send("R5 code3 none",   2'd3, 1'b0, 2, 8'h0F, 8'h10, 8'h00, 0, 1'b0);
    send("R7 gaps",         2'd0, 1'b1, 3, 8'h0F, 8'h38, 8'hF0, 3, 1'b0);
    send("R8 late pfx",     2'd0, 1'b0, 3, 8'h0F, 8'h3A, 8'h44, 1, 1'b1);
    send("R4 sel as op",    2'd0, 1'b0, 3, 8'h0F, 8'h3A, 8'h3A, 0, 1'b0);
    send("R11 modrm",       2'd0, 1'b0, 2, 8'h0F, 8'h81, 8'h00, 2, 1'b0);

    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule